// File: doc/BRIEF.md
# Clocked Synchronous Serial Transmitter

This block sends 8-bit frames over a two-wire synchronous link: a data line and a serial clock. A host places a byte in a one-entry holding buffer. The transmitter copies the byte into a shift register as soon as the shifter is free, and marks the buffer empty again. It then sends the bits least significant first. Each bit changes on a falling clock edge and is meant to be sampled by the receiver on the rising edge. The serial clock comes from one of two sources. It is made inside the block, with each half period lasting a programmable number of system clocks. Or it is taken from an external clock pin, which passes through a two-stage synchroniser and an edge detector.

The buffer-empty state is looked at once per frame, on the rising clock edge of the last bit. If the host has refilled the buffer by then, the next frame follows with no idle time. If it has not, the block raises its end flag. It then keeps the data line at the level of the last bit and parks the serial clock high. Two interrupt requests are provided, each gated by its own enable: one follows the buffer-empty flag and the other follows the end flag. A host write that arrives while the buffer is still full is dropped, and it sets a sticky overrun indication.

Top module: `sst_tx`

## Requirements
- R1: After reset, txd=1, sck_out=1, empty_flag=1, end_flag=1 and overrun=0.
- R2: A wr_stb pulse while empty_flag=1 stores wr_data in the buffer. At the next clock edge it clears empty_flag and end_flag.
- R3: While the shifter is idle and empty_flag=0, the buffer is copied into the shifter on the next edge, and empty_flag returns to 1 on that edge. In internal mode, the first falling serial clock edge, carrying bit 0, comes one edge after that.
- R4: Bits leave least significant first. txd changes only together with a falling serial clock edge and stays stable through the low phase that ends in the rising edge.
- R5: In internal mode, each frame has exactly 8 low pulses on sck_out. Every high and low phase inside a frame lasts max(div,1) system clocks, so div=0 acts as 1.
- R6: If empty_flag=0 at the rising edge of bit 7, the next byte is loaded on that edge and empty_flag goes to 1. end_flag stays 0, and the high phase before the next bit 0 lasts exactly one half period.
- R7: If empty_flag=1 at the rising edge of bit 7, end_flag goes to 1 on that edge. Afterwards sck_out stays 1 and txd keeps the value of bit 7.
- R8: A wr_stb while empty_flag=0 is ignored, so the buffered byte is the one that is sent. It sets overrun, which stays 1 until reset.
- R9: With ext_mode=1, sck_out is held at 1. Each bit is driven after a falling edge of sck_in and advances on its rising edges, with three system clocks of latency from the synchroniser and the edge detector.
- R10: irq_empty equals empty_flag AND ie_empty, and irq_end equals end_flag AND ie_end, as levels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| wr_stb | input | 1 | Host write strobe; also clears the empty flag |
| wr_data | input | 8 | Byte to transmit |
| ext_mode | input | 1 | 1 = serial clock taken from sck_in |
| div | input | 8 | Internal half period in system clocks (0 acts as 1) |
| sck_in | input | 1 | External serial clock |
| ie_empty | input | 1 | Buffer-empty interrupt enable |
| ie_end | input | 1 | Transmit-end interrupt enable |
| txd | output | 1 | Serial data |
| sck_out | output | 1 | Serial clock output, idles high |
| empty_flag | output | 1 | Buffer empty |
| end_flag | output | 1 | Transmission ended |
| irq_empty | output | 1 | Buffer-empty interrupt request |
| irq_end | output | 1 | Transmit-end interrupt request |
| overrun | output | 1 | Sticky: a write was dropped |

## Verification
Take W as the edge that captures a write. The flags change at W, the load happens at W+1 and the first falling clock edge comes at W+2. In internal mode, end_flag rises at W+2+15·d, where d is the half period. The bench counts system clock edges from W and samples on the falling system clock edge at exactly those counts. For the end flag it also checks the cycle just before, to prove the flag is not early. A monitor records, for each pulse, the phase lengths, the bit at the falling edge and the bit at the rising edge. From these it checks the half period, the bit order and gapless chaining. In external mode the bench holds each sck_in phase for six clocks, which is longer than the three-clock latency, and samples txd before it raises sck_in.

// File: rtl/sst_pkg.sv
package sst_pkg;

  // serial clock events seen by the shifter for one system clock
  typedef struct packed {
    logic fall;
    logic rise;
  } sck_ev_t;

  // half period in system clocks; zero is treated as one
  function automatic int unsigned half_cycles(input int unsigned d);
    return (d == 0) ? 1 : d;
  endfunction

endpackage

// File: rtl/sst_clkgen.sv
module sst_clkgen import sst_pkg::*; #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             sck,
  output sck_ev_t          ev
);
  logic [DIV_W-1:0] hc;
  logic [DIV_W-1:0] lim;
  logic             wrap;

  assign lim  = DIV_W'(half_cycles(32'(div)) - 1);
  assign wrap = run && (hc >= lim);

  always_comb begin
    ev.fall = wrap && sck;
    ev.rise = wrap && !sck;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck <= 1'b1;
      hc  <= '0;
    end else if (!run) begin
      sck <= 1'b1;
      hc  <= lim;
    end else if (wrap) begin
      sck <= ~sck;
      hc  <= '0;
    end else begin
      hc  <= hc + 1'b1;
    end
  end
endmodule

// File: rtl/sst_ext_edge.sv
module sst_ext_edge import sst_pkg::*; (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    sck_in,
  output sck_ev_t ev
);
  logic s1, s2, prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1   <= 1'b1;
      s2   <= 1'b1;
      prev <= 1'b1;
    end else begin
      s1   <= sck_in;
      s2   <= s1;
      prev <= s2;
    end
  end

  always_comb begin
    ev.fall = prev && !s2;
    ev.rise = !prev && s2;
  end
endmodule

// File: rtl/sst_shifter.sv
module sst_shifter import sst_pkg::*; #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic [DATA_W-1:0] wr_data,
  input  sck_ev_t           ev,
  output logic              txd,
  output logic              busy,
  output logic              empty,
  output logic              tend,
  output logic              overrun,
  output logic              shift_evt,
  output logic              load_evt,
  output logic              stop_evt
);
  localparam int CNT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

  logic [DATA_W-1:0] tdr;
  logic [DATA_W-1:0] sr;
  logic [CNT_W-1:0]  bitn;
  logic              wr_ok, last_rise, load_idle, load_chain, adv_evt;

  assign wr_ok      = wr_stb && empty;
  assign shift_evt  = busy && ev.fall;
  assign adv_evt    = busy && ev.rise;
  assign last_rise  = adv_evt && (bitn == LAST);
  assign load_idle  = !busy && !empty;
  assign load_chain = last_rise && !empty;
  assign load_evt   = load_idle || load_chain;
  assign stop_evt   = last_rise && empty;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tdr     <= '0;
      sr      <= '0;
      bitn    <= '0;
      txd     <= 1'b1;
      busy    <= 1'b0;
      empty   <= 1'b1;
      tend    <= 1'b1;
      overrun <= 1'b0;
    end else begin
      if (wr_ok) begin
        tdr   <= wr_data;
        empty <= 1'b0;
      end else if (load_evt) begin
        empty <= 1'b1;
      end
      if (wr_stb && !empty) overrun <= 1'b1;
      if (wr_ok)         tend <= 1'b0;
      else if (stop_evt) tend <= 1'b1;
      if (load_idle)     busy <= 1'b1;
      else if (stop_evt) busy <= 1'b0;
      if (load_evt) sr <= tdr;
      else if (shift_evt) begin
        txd <= sr[0];
        sr  <= sr >> 1;
      end
      if (load_idle)    bitn <= '0;
      else if (adv_evt) bitn <= bitn + 1'b1;
    end
  end
endmodule

// File: rtl/sst_tx.sv
module sst_tx import sst_pkg::*; #(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              ext_mode,
  input  logic [DIV_W-1:0]  div,
  input  logic              sck_in,
  input  logic              ie_empty,
  input  logic              ie_end,
  output logic              txd,
  output logic              sck_out,
  output logic              empty_flag,
  output logic              end_flag,
  output logic              irq_empty,
  output logic              irq_end,
  output logic              overrun
);
  sck_ev_t int_ev, ext_ev, sel_ev;
  logic    int_sck, busy, shift_evt, load_evt, stop_evt;

  sst_clkgen #(.DIV_W(DIV_W)) u_clkgen (
    .clk(clk), .rst_n(rst_n), .run(busy && !ext_mode), .div(div),
    .sck(int_sck), .ev(int_ev));

  sst_ext_edge u_ext (.clk(clk), .rst_n(rst_n), .sck_in(sck_in), .ev(ext_ev));

  assign sel_ev = ext_mode ? ext_ev : int_ev;

  sst_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_data(wr_data), .ev(sel_ev),
    .txd(txd), .busy(busy), .empty(empty_flag), .tend(end_flag),
    .overrun(overrun), .shift_evt(shift_evt), .load_evt(load_evt),
    .stop_evt(stop_evt));

  assign sck_out   = ext_mode ? 1'b1 : int_sck;
  assign irq_empty = empty_flag && ie_empty;
  assign irq_end   = end_flag && ie_end;
endmodule

// File: rtl/sst_tx_chk.sv
module sst_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic wr_stb,
  input logic empty_flag,
  input logic end_flag,
  input logic overrun,
  input logic txd,
  input logic sck_out,
  input logic busy,
  input logic shift_evt,
  input logic load_evt,
  input logic stop_evt
);
  // R2
  wr_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb && empty_flag |=> !empty_flag && !end_flag);
  // R8
  wr_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb && !empty_flag |=> overrun);
  // R8
  overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun);
  // R3
  load_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |=> empty_flag);
  // R4
  txd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_evt |=> $stable(txd));
  // R7
  idle_sck_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> sck_out);
  // R7
  stop_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt && !wr_stb |=> end_flag && !busy);
  // R6
  load_stop_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({load_evt, stop_evt}));
endmodule

bind sst_tx sst_tx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .empty_flag(empty_flag),
  .end_flag(end_flag), .overrun(overrun), .txd(txd), .sck_out(sck_out),
  .busy(busy), .shift_evt(shift_evt), .load_evt(load_evt), .stop_evt(stop_evt));

// File: tb/sst_tx_tb.sv
module sst_tx_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_stb = 1'b0;
  logic [7:0] wr_data = '0;
  logic       ext_mode = 1'b0;
  logic [7:0] div = 8'd2;
  logic       sck_in = 1'b1;
  logic       ie_empty = 1'b1;
  logic       ie_end = 1'b0;
  logic       txd, sck_out, empty_flag, end_flag, irq_empty, irq_end, overrun;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  int last_w = 0;
  bit done = 0;

  // monitor records, per pulse: bit at fall, bit at rise, low and preceding high length
  int   cap_cnt = 0;
  int   last_edge = 0;
  logic prev_sck = 1'b1;
  logic cap_bit [128];
  logic fall_bit [128];
  int   lo_len [128];
  int   hi_len [128];

  sst_tx u_dut (.*);

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (prev_sck && !sck_out) begin
      hi_len[cap_cnt]   = cyc - last_edge;
      fall_bit[cap_cnt] = txd;
      last_edge = cyc;
    end
    if (!prev_sck && sck_out) begin
      lo_len[cap_cnt]  = cyc - last_edge;
      cap_bit[cap_cnt] = txd;
      last_edge = cyc;
      cap_cnt++;
    end
    prev_sck = sck_out;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr_byte(input logic [7:0] b);
    @(negedge clk);
    wr_stb = 1'b1;
    wr_data = b;
    @(negedge clk);
    wr_stb = 1'b0;
    last_w = cyc;
  endtask

  task automatic wait_until(input int target);
    while (cyc < target) @(negedge clk);
  endtask

  // checks one captured internal-mode frame starting at pulse index base
  task automatic check_frame(input int base, input logic [7:0] b, input int d, input bit chained);
    logic [7:0] got = '0;
    bit len_ok = 1;
    bit stab_ok = 1;
    for (int k = 0; k < 8; k++) begin
      got[k] = cap_bit[base + k];
      if (fall_bit[base + k] !== cap_bit[base + k]) stab_ok = 0;
      if (lo_len[base + k] != d) len_ok = 0;
      if ((k > 0 || chained) && hi_len[base + k] != d) len_ok = 0;
    end
    check(got == b, "R4 lsb-first frame bits", int'(got), int'(b));
    check(stab_ok, "R4 txd stable across low phase", int'(stab_ok), 1);
    check(len_ok, "R5 half period lengths", int'(len_ok), 1);
  endtask

  task automatic t_reset();
    check(txd === 1'b1, "R1 txd after reset", int'(txd), 1);
    check(sck_out === 1'b1, "R1 sck_out after reset", int'(sck_out), 1);
    check(empty_flag === 1'b1 && end_flag === 1'b1, "R1 flags after reset",
          int'({empty_flag, end_flag}), 3);
    check(overrun === 1'b0, "R1 overrun after reset", int'(overrun), 0);
    check(irq_empty === 1'b1 && irq_end === 1'b0, "R10 irq with ie_empty=1 ie_end=0",
          int'({irq_empty, irq_end}), 2);
  endtask

  task automatic t_single(input logic [7:0] b, input int dv);
    int d = (dv == 0) ? 1 : dv;
    int base = cap_cnt;
    div = 8'(dv);
    ie_end = 1'b1;
    wr_byte(b);
    check(!empty_flag && !end_flag, "R2 write clears flags", int'({empty_flag, end_flag}), 0);
    check(!irq_empty && !irq_end, "R10 irqs drop", int'({irq_empty, irq_end}), 0);
    @(negedge clk);
    check(empty_flag === 1'b1 && sck_out === 1'b1, "R3 load sets empty, clock not yet low",
          int'({empty_flag, sck_out}), 3);
    check(irq_empty === 1'b1, "R10 irq_empty on reload", int'(irq_empty), 1);
    @(negedge clk);
    check(sck_out === 1'b0 && txd === b[0], "R3 first fall carries bit 0",
          int'({sck_out, txd}), int'({1'b0, b[0]}));
    wait_until(last_w + 1 + 15 * d);
    check(end_flag === 1'b0, "R7 end flag not early", int'(end_flag), 0);
    @(negedge clk);
    check(end_flag === 1'b1 && irq_end === 1'b1, "R7 end flag at bit-7 rise",
          int'({end_flag, irq_end}), 3);
    repeat (3 * d + 2) @(negedge clk);
    check(sck_out === 1'b1 && txd === b[7], "R7 clock parked high, txd holds bit 7",
          int'({sck_out, txd}), int'({1'b1, b[7]}));
    check(cap_cnt - base == 8, "R5 eight pulses per frame", cap_cnt - base, 8);
    check_frame(base, b, d, 0);
  endtask

  task automatic t_chain(input logic [7:0] b0, input logic [7:0] b1, input int d);
    int base = cap_cnt;
    int w0;
    div = 8'(d);
    wr_byte(b0);
    w0 = last_w;
    @(negedge clk);
    wr_byte(b1);
    wait_until(w0 + 2 + 15 * d);
    check(end_flag === 1'b0 && empty_flag === 1'b1, "R6 reload at bit-7 rise, no end",
          int'({end_flag, empty_flag}), 1);
    wait_until(w0 + 1 + 31 * d);
    check(end_flag === 1'b0, "R6 second frame not ended early", int'(end_flag), 0);
    @(negedge clk);
    check(end_flag === 1'b1, "R7 end after second frame", int'(end_flag), 1);
    repeat (2 * d + 2) @(negedge clk);
    check(cap_cnt - base == 16, "R6 sixteen pulses back to back", cap_cnt - base, 16);
    check(hi_len[base + 8] == d, "R6 no gap between frames", hi_len[base + 8], d);
    check_frame(base, b0, d, 0);
    check_frame(base + 8, b1, d, 1);
  endtask

  task automatic t_overrun(input logic [7:0] x, input logic [7:0] a, input logic [7:0] bad, input int d);
    int base = cap_cnt;
    int w0;
    div = 8'(d);
    wr_byte(x);
    w0 = last_w;
    @(negedge clk);
    wr_byte(a);
    check(overrun === 1'b0, "R8 no overrun on accepted write", int'(overrun), 0);
    wr_byte(bad);
    check(overrun === 1'b1, "R8 overrun on write while full", int'(overrun), 1);
    wait_until(w0 + 2 + 31 * d);
    repeat (2 * d + 2) @(negedge clk);
    check(cap_cnt - base == 16, "R8 two frames only", cap_cnt - base, 16);
    check_frame(base + 8, a, d, 1);
    check(overrun === 1'b1, "R8 overrun sticky", int'(overrun), 1);
  endtask

  task automatic t_ext(input logic [7:0] b, input logic prev_bit);
    logic [7:0] got = '0;
    bit sck_ok = 1;
    ext_mode = 1'b1;
    div = 8'd1;
    wr_byte(b);
    repeat (4) @(negedge clk);
    check(empty_flag === 1'b1 && txd === prev_bit, "R9 loaded, txd waits for sck_in",
          int'({empty_flag, txd}), int'({1'b1, prev_bit}));
    for (int k = 0; k < 8; k++) begin
      sck_in = 1'b0;
      repeat (6) @(negedge clk) if (sck_out !== 1'b1) sck_ok = 0;
      got[k] = txd;
      if (k == 7) check(end_flag === 1'b0, "R9 end not before last rise", int'(end_flag), 0);
      sck_in = 1'b1;
      repeat (6) @(negedge clk) if (sck_out !== 1'b1) sck_ok = 0;
    end
    check(got == b, "R9 external clock frame bits", int'(got), int'(b));
    check(sck_ok, "R9 sck_out held high", int'(sck_ok), 1);
    check(end_flag === 1'b1 && txd === b[7], "R9 end after last rise, txd holds",
          int'({end_flag, txd}), int'({1'b1, b[7]}));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_single(8'hA5, 2);
    t_single(8'h3C, 0);
    t_chain(8'h81, 8'h6E, 3);
    t_overrun(8'hF0, 8'h17, 8'hCC, 2);
    t_ext(8'h4B, 1'b0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule